// File: doc/BRIEF.md
# Burst-Splitting Peripheral Bridge

The bridge sits between one 32-bit upstream initiator port and a set of peripheral targets that can only take single accesses. Each upstream request names a thread and carries a start address, a beat count, a transfer size (8, 16 or 32 bits) and the write data for every beat. Each thread has one request slot. Full slots are served in round-robin order. A served request is decoded to one target and cut into single accesses with incrementing addresses. Narrow data is steered onto the little-endian byte lanes.

Every completed target access produces one response beat towards the initiator, tagged with the thread of the request. An address that falls in no target window produces an error response and no access at all. The control is a five-state machine:

- ST_IDLE arbitrates among full slots. It moves to ST_DECODE when one is granted.
- ST_DECODE resolves the target. It goes to ST_ISSUE on a hit and to ST_FAULT on a miss.
- ST_ISSUE presents one access and always moves to ST_WAIT.
- ST_WAIT holds the access until the target acknowledges it. It then returns to ST_ISSUE for the next beat, or to ST_IDLE after the last beat.
- ST_FAULT sends the error response and returns to ST_IDLE.

Top module: `pbus_split_bridge`

## Requirements
- R1: `req_ready[t]` is high exactly when thread t's slot is empty. A request is taken on a clock edge where `req_valid` is high and the slot of `req_thread` is empty. A full slot of one thread does not stop other threads' requests from being taken.
- R2: With the bridge idle, a taken request raises its target's `tgt_valid` three clock edges after the edge that took it.
- R3: A request with `req_len` = L is issued as L+1 single accesses, in order. The address steps by 1, 2 or 4 bytes for size code 0 (byte), 1 (halfword) and 2 or 3 (word). At most one `tgt_valid` bit is high at a time.
- R4: Byte enables for an access at address A are as follows. Size 0 gives `4'b0001 << A[1:0]`. Size 1 gives `4'b0011` when A[1] is 0 and `4'b1100` when A[1] is 1. Word sizes give `4'b1111`.
- R5: Beat k of a write takes bits [32k+31:32k] of `req_wdata`. For narrow sizes, its low byte or halfword is shifted to the lanes chosen by the low address bits, and the other lanes are zero.
- R6: Read response data is the enabled lanes of the target word, shifted down to bit 0, with the upper bits zero. Write responses carry zero data.
- R7: `rsp_valid` pulses on the clock edge after the edge where the active target's `tgt_ack` is sampled high. The pulse carries the request's thread, `rsp_err` low, and `rsp_last` high only on the final beat.
- R8: After a burst of thread g finishes, the next grant goes to the first thread with a full slot in the order g+1, g+2, … (modulo thread count).
- R9: All beats of one burst finish before any access of another request begins.
- R10: Target i owns the page `addr[31:12]` = 4 + i. An access holds `tgt_addr`, `tgt_be`, `tgt_wdata`, `tgt_we` and `tgt_valid` steady until it is acknowledged.
- R11: A request whose start address is in no target page gives exactly one response, with `rsp_err`=1, `rsp_last`=1 and zero data. It is due three edges after it is taken, and no target access is made for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_thread | input | THR_W | Thread of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | MAX_BEATS*32 | Write data, one 32-bit slice per beat |
| req_ready | output | NUM_THREADS | Per-thread slot empty |
| rsp_valid | output | 1 | Response beat |
| rsp_thread | output | THR_W | Thread of the response |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_err | output | 1 | Decode miss |
| rsp_last | output | 1 | Final beat of the request |
| tgt_valid | output | NUM_TARGETS | One-hot target access strobe |
| tgt_we | output | 1 | Access is a write |
| tgt_addr | output | ADDR_W | Access byte address |
| tgt_be | output | 4 | Byte enables |
| tgt_wdata | output | 32 | Lane-steered write data |
| tgt_ack | input | NUM_TARGETS | Per-target access done |
| tgt_rdata | input | NUM_TARGETS*32 | Per-target read word |

## Verification
A target strobe is due three edges after the edge that takes the request on an idle bridge. A decode-miss error response is due at that same point. A response beat is due one edge after the acknowledging edge. The bench checks the first two windows by counting falling edges from the accepting edge and sampling the outputs at each one. It checks the one-edge response timing and the ordering through a scoreboard. Driver tasks queue the expected accesses and responses in the order the round-robin rule predicts. Monitors on the falling edge compare each acknowledged access and each response pulse against the queue heads.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int BUS_W     = 32;
    localparam int BUS_BYTES = BUS_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xsize_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECODE = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_FAULT  = 3'd4
    } br_state_e;

    function automatic logic [2:0] size_step(xsize_e s);
        unique case (s)
            SZ_BYTE:         return 3'd1;
            SZ_HALF:         return 3'd2;
            SZ_WORD, SZ_WIDE: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/psb_rr_arb.sv
module psb_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] pick,
    output logic          any
);

    generate
        if (N == 1) begin : g_single
            assign pick = '0;
            assign any  = pend[0];
        end else begin : g_multi
            always_comb begin
                any  = 1'b0;
                pick = last;
                for (int k = 1; k <= N; k++) begin
                    if (!any && pend[(int'(last) + k) % N]) begin
                        any  = 1'b1;
                        pick = IW'((int'(last) + k) % N);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/psb_lane.sv
module psb_lane
    import psb_pkg::*;
(
    input  xsize_e            size,
    input  logic [1:0]        lo,
    input  logic [BUS_W-1:0]  wbeat,
    input  logic [BUS_W-1:0]  rword,
    output logic [BUS_BYTES-1:0] be,
    output logic [BUS_W-1:0]  wlane,
    output logic [BUS_W-1:0]  rval
);

    logic [4:0] bsh;
    logic [4:0] hsh;

    assign bsh = {lo, 3'b000};
    assign hsh = {lo[1], 4'b0000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be    = 4'b0001 << lo;
                wlane = {24'h0, wbeat[7:0]} << bsh;
                rval  = (rword >> bsh) & 32'h0000_00FF;
            end
            SZ_HALF: begin
                be    = lo[1] ? 4'b1100 : 4'b0011;
                wlane = {16'h0, wbeat[15:0]} << hsh;
                rval  = (rword >> hsh) & 32'h0000_FFFF;
            end
            SZ_WORD, SZ_WIDE: begin
                be    = 4'b1111;
                wlane = wbeat;
                rval  = rword;
            end
        endcase
    end

endmodule

// File: rtl/psb_addr_decode.sv
module psb_addr_decode #(
    parameter int          ADDR_W      = 32,
    parameter int          PAGE_BITS   = 12,
    parameter int unsigned BASE_PAGE   = 4,
    parameter int          NUM_TARGETS = 4,
    parameter int          TW          = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [TW-1:0]     idx
);

    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] off;

    assign page = addr[ADDR_W-1:PAGE_BITS];
    assign off  = page - PAGE_W'(BASE_PAGE);
    assign hit  = (page >= PAGE_W'(BASE_PAGE)) && (off < PAGE_W'(NUM_TARGETS));
    assign idx  = TW'(off);

endmodule

// File: rtl/pbus_split_bridge.sv
module pbus_split_bridge
    import psb_pkg::*;
#(
    parameter int          NUM_THREADS = 4,
    parameter int          NUM_TARGETS = 4,
    parameter int          ADDR_W      = 32,
    parameter int          PAGE_BITS   = 12,
    parameter int unsigned BASE_PAGE   = 4,
    parameter int          MAX_BEATS   = 4,
    localparam int         THR_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int         TGT_W       = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1,
    localparam int         LEN_W       = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    localparam int         WD_W        = MAX_BEATS * BUS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [THR_W-1:0]            req_thread,
    input  logic                        req_we,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [LEN_W-1:0]            req_len,
    input  logic [1:0]                  req_size,
    input  logic [WD_W-1:0]             req_wdata,
    output logic [NUM_THREADS-1:0]      req_ready,
    output logic                        rsp_valid,
    output logic [THR_W-1:0]            rsp_thread,
    output logic [BUS_W-1:0]            rsp_rdata,
    output logic                        rsp_err,
    output logic                        rsp_last,
    output logic [NUM_TARGETS-1:0]      tgt_valid,
    output logic                        tgt_we,
    output logic [ADDR_W-1:0]           tgt_addr,
    output logic [BUS_BYTES-1:0]        tgt_be,
    output logic [BUS_W-1:0]            tgt_wdata,
    input  logic [NUM_TARGETS-1:0]      tgt_ack,
    input  logic [NUM_TARGETS*BUS_W-1:0] tgt_rdata
);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        xsize_e            size;
        logic [WD_W-1:0]   wdata;
    } slot_t;

    // per-thread request slots
    slot_t                  slot_q [NUM_THREADS];
    logic [NUM_THREADS-1:0] slot_full_q;

    // burst context
    br_state_e         state_q, state_d;
    logic [THR_W-1:0]  cur_thr_q;
    logic              cur_we_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [LEN_W-1:0]  beat_q;
    xsize_e            cur_size_q;
    logic [WD_W-1:0]   cur_wd_q;
    logic [TGT_W-1:0]  cur_tgt_q;
    logic [THR_W-1:0]  rr_ptr_q;

    // registered outputs
    logic [NUM_TARGETS-1:0] tgt_valid_q;
    logic                   tgt_we_q;
    logic [ADDR_W-1:0]      tgt_addr_q;
    logic [BUS_BYTES-1:0]   tgt_be_q;
    logic [BUS_W-1:0]       tgt_wdata_q;
    logic                   rsp_valid_q;
    logic [THR_W-1:0]       rsp_thread_q;
    logic [BUS_W-1:0]       rsp_rdata_q;
    logic                   rsp_err_q;
    logic                   rsp_last_q;

    // helpers
    logic              arb_any;
    logic [THR_W-1:0]  arb_pick;
    logic              dec_hit;
    logic [TGT_W-1:0]  dec_idx;
    logic [BUS_BYTES-1:0] lane_be;
    logic [BUS_W-1:0]  lane_w;
    logic [BUS_W-1:0]  lane_r;
    logic [BUS_W-1:0]  beat_wd;
    logic [BUS_W-1:0]  sel_rword;
    logic              beat_done;
    logic              take_req;

    psb_rr_arb #(
        .N  (NUM_THREADS),
        .IW (THR_W)
    ) u_arb (
        .pend (slot_full_q),
        .last (rr_ptr_q),
        .pick (arb_pick),
        .any  (arb_any)
    );

    psb_addr_decode #(
        .ADDR_W      (ADDR_W),
        .PAGE_BITS   (PAGE_BITS),
        .BASE_PAGE   (BASE_PAGE),
        .NUM_TARGETS (NUM_TARGETS),
        .TW          (TGT_W)
    ) u_dec (
        .addr (cur_addr_q),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    assign beat_wd   = cur_wd_q[beat_q*BUS_W +: BUS_W];
    assign sel_rword = tgt_rdata[cur_tgt_q*BUS_W +: BUS_W];

    psb_lane u_lane (
        .size  (cur_size_q),
        .lo    (cur_addr_q[1:0]),
        .wbeat (beat_wd),
        .rword (sel_rword),
        .be    (lane_be),
        .wlane (lane_w),
        .rval  (lane_r)
    );

    assign beat_done = (state_q == ST_WAIT) && tgt_ack[cur_tgt_q];
    assign take_req  = req_valid && (int'(req_thread) < NUM_THREADS)
                       && !slot_full_q[req_thread];
    assign req_ready = ~slot_full_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arb_any) state_d = ST_DECODE;
            ST_DECODE: state_d = dec_hit ? ST_ISSUE : ST_FAULT;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (beat_done) state_d = (left_q == '0) ? ST_IDLE : ST_ISSUE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // slots, context and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_full_q  <= '0;
            for (int t = 0; t < NUM_THREADS; t++) slot_q[t] <= '0;
            cur_thr_q    <= '0;
            cur_we_q     <= 1'b0;
            cur_addr_q   <= '0;
            left_q       <= '0;
            beat_q       <= '0;
            cur_size_q   <= SZ_BYTE;
            cur_wd_q     <= '0;
            cur_tgt_q    <= '0;
            rr_ptr_q     <= THR_W'(NUM_THREADS - 1);
            tgt_valid_q  <= '0;
            tgt_we_q     <= 1'b0;
            tgt_addr_q   <= '0;
            tgt_be_q     <= '0;
            tgt_wdata_q  <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_thread_q <= '0;
            rsp_rdata_q  <= '0;
            rsp_err_q    <= 1'b0;
            rsp_last_q   <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;

            if (take_req) begin
                slot_full_q[req_thread]  <= 1'b1;
                slot_q[req_thread].we    <= req_we;
                slot_q[req_thread].addr  <= req_addr;
                slot_q[req_thread].len   <= req_len;
                slot_q[req_thread].size  <= xsize_e'(req_size);
                slot_q[req_thread].wdata <= req_wdata;
            end

            unique case (state_q)
                ST_IDLE: begin
                    if (arb_any) begin
                        slot_full_q[arb_pick] <= 1'b0;
                        cur_thr_q  <= arb_pick;
                        cur_we_q   <= slot_q[arb_pick].we;
                        cur_addr_q <= slot_q[arb_pick].addr;
                        left_q     <= slot_q[arb_pick].len;
                        cur_size_q <= slot_q[arb_pick].size;
                        cur_wd_q   <= slot_q[arb_pick].wdata;
                        beat_q     <= '0;
                    end
                end
                ST_DECODE: begin
                    cur_tgt_q <= dec_idx;
                end
                ST_ISSUE: begin
                    tgt_valid_q <= NUM_TARGETS'(1) << cur_tgt_q;
                    tgt_we_q    <= cur_we_q;
                    tgt_addr_q  <= cur_addr_q;
                    tgt_be_q    <= lane_be;
                    tgt_wdata_q <= cur_we_q ? lane_w : '0;
                end
                ST_WAIT: begin
                    if (beat_done) begin
                        tgt_valid_q  <= '0;
                        rsp_valid_q  <= 1'b1;
                        rsp_thread_q <= cur_thr_q;
                        rsp_rdata_q  <= cur_we_q ? '0 : lane_r;
                        rsp_err_q    <= 1'b0;
                        rsp_last_q   <= (left_q == '0);
                        if (left_q == '0) begin
                            rr_ptr_q <= cur_thr_q;
                        end else begin
                            cur_addr_q <= cur_addr_q + ADDR_W'(size_step(cur_size_q));
                            left_q     <= left_q - 1'b1;
                            beat_q     <= beat_q + 1'b1;
                        end
                    end
                end
                ST_FAULT: begin
                    rsp_valid_q  <= 1'b1;
                    rsp_thread_q <= cur_thr_q;
                    rsp_rdata_q  <= '0;
                    rsp_err_q    <= 1'b1;
                    rsp_last_q   <= 1'b1;
                    rr_ptr_q     <= cur_thr_q;
                end
                default: ;
            endcase
        end
    end

    assign tgt_valid  = tgt_valid_q;
    assign tgt_we     = tgt_we_q;
    assign tgt_addr   = tgt_addr_q;
    assign tgt_be     = tgt_be_q;
    assign tgt_wdata  = tgt_wdata_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_thread = rsp_thread_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_last   = rsp_last_q;

endmodule

// File: rtl/pbus_split_bridge_chk.sv
module pbus_split_bridge_chk #(
    parameter int NUM_TARGETS = 4,
    parameter int ADDR_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_TARGETS-1:0] tgt_valid,
    input logic [NUM_TARGETS-1:0] tgt_ack,
    input logic                   tgt_we,
    input logic [ADDR_W-1:0]      tgt_addr,
    input logic [3:0]             tgt_be,
    input logic [31:0]            tgt_wdata,
    input logic                   rsp_valid,
    input logic                   rsp_err,
    input logic                   rsp_last
);

    // R3: never more than one target strobed
    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_valid));

    // R10: access held steady until acknowledged
    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tgt_valid) && !(|(tgt_valid & tgt_ack))) |=>
            ($stable(tgt_valid) && $stable(tgt_addr) && $stable(tgt_be)
             && $stable(tgt_wdata) && $stable(tgt_we)));

    // R7: acknowledged access answered on the next edge
    assert_rsp_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tgt_valid & tgt_ack)) |=> (rsp_valid && !rsp_err));

    // R11: error response is final and no access is active with it
    assert_err_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_last && (tgt_valid == '0)));

endmodule

bind pbus_split_bridge pbus_split_bridge_chk #(
    .NUM_TARGETS (NUM_TARGETS),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_valid (tgt_valid),
    .tgt_ack   (tgt_ack),
    .tgt_we    (tgt_we),
    .tgt_addr  (tgt_addr),
    .tgt_be    (tgt_be),
    .tgt_wdata (tgt_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_last  (rsp_last)
);

// File: tb/pbus_split_bridge_tb.sv
module pbus_split_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NTH  = 4;
    localparam int NTG  = 4;
    localparam int AW   = 32;
    localparam int MAXB = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_thread = '0;
    logic              req_we = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [1:0]        req_len = '0;
    logic [1:0]        req_size = '0;
    logic [MAXB*32-1:0] req_wdata = '0;
    logic [NTH-1:0]    req_ready;
    logic              rsp_valid;
    logic [1:0]        rsp_thread;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic              rsp_last;
    logic [NTG-1:0]    tgt_valid;
    logic              tgt_we;
    logic [AW-1:0]     tgt_addr;
    logic [3:0]        tgt_be;
    logic [31:0]       tgt_wdata;
    logic [NTG-1:0]    tgt_ack = '0;
    logic [NTG*32-1:0] tgt_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_split_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_thread(req_thread), .req_we(req_we),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_thread(rsp_thread), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_last(rsp_last),
        .tgt_valid(tgt_valid), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
        .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
        .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
    );

    function automatic logic [31:0] m_rword(int tg, logic [31:0] a);
        return {4'hC, 4'(tg), 8'h5A, a[15:2], 2'b00};
    endfunction

    // target models: acknowledge in the second cycle of each access
    for (genvar i = 0; i < NTG; i++) begin : g_tgt
        assign tgt_rdata[i*32 +: 32] = m_rword(i, tgt_addr);
        always @(posedge clk) tgt_ack[i] <= tgt_valid[i] & ~tgt_ack[i];
    end

    typedef struct { int tg; logic we; logic [31:0] addr; logic [3:0] be; logic [31:0] wd; } acc_t;
    typedef struct { int thr; logic [31:0] data; logic err; logic last; } rsp_t;
    acc_t exp_acc[$];
    rsp_t exp_rsp[$];

    int  checks = 0;
    int  errors = 0;
    bit  done_flag = 1'b0;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] m_be(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            2'd0:    return 4'b0001 << lo;
            2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] m_wl(logic [1:0] sz, logic [1:0] lo, logic [31:0] w);
        case (sz)
            2'd0:    return {24'h0, w[7:0]} << (8 * lo);
            2'd1:    return lo[1] ? {w[15:0], 16'h0} : {16'h0, w[15:0]};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] m_rv(logic [1:0] sz, logic [1:0] lo, logic [31:0] r);
        case (sz)
            2'd0:    return (r >> (8 * lo)) & 32'hFF;
            2'd1:    return lo[1] ? {16'h0, r[31:16]} : {16'h0, r[15:0]};
            default: return r;
        endcase
    endfunction

    task automatic expect_burst(int thr, logic we, logic [31:0] addr, int len,
                                logic [1:0] sz, logic [MAXB*32-1:0] wd);
        int step;
        step = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int k = 0; k <= len; k++) begin
            acc_t x;
            rsp_t r;
            x.addr = addr + 32'(k * step);
            x.tg   = int'(x.addr >> 12) - 4;
            x.we   = we;
            x.be   = m_be(sz, x.addr[1:0]);
            x.wd   = we ? m_wl(sz, x.addr[1:0], wd[k*32 +: 32]) : 32'h0;
            exp_acc.push_back(x);
            r.thr  = thr;
            r.data = we ? 32'h0 : m_rv(sz, x.addr[1:0], m_rword(x.tg, x.addr));
            r.err  = 1'b0;
            r.last = (k == len);
            exp_rsp.push_back(r);
        end
    endtask

    task automatic expect_fault(int thr);
        rsp_t r;
        r.thr = thr; r.data = 32'h0; r.err = 1'b1; r.last = 1'b1;
        exp_rsp.push_back(r);
    endtask

    task automatic send(int thr, logic we, logic [31:0] addr, int len,
                        logic [1:0] sz, logic [MAXB*32-1:0] wd);
        @(negedge clk);
        while (!req_ready[thr]) @(negedge clk);
        req_valid  = 1'b1;
        req_thread = 2'(thr);
        req_we     = we;
        req_addr   = addr;
        req_len    = 2'(len);
        req_size   = sz;
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic drain();
        for (int n = 0; n < 400 && (exp_acc.size() != 0 || exp_rsp.size() != 0); n++)
            @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: access scoreboard (R3, R4, R5, R9, R10) and response scoreboard (R6, R7, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NTG; i++) begin
                if (tgt_valid[i] && tgt_ack[i]) begin
                    if (exp_acc.size() == 0) begin
                        check(1'b0, "R11/R9", "unexpected access addr", tgt_addr, 32'h0);
                    end else begin
                        acc_t x;
                        x = exp_acc.pop_front();
                        check(i == x.tg, "R10", "target index", 32'(i), 32'(x.tg));
                        check(tgt_addr == x.addr, "R3", "access address", tgt_addr, x.addr);
                        check(tgt_we == x.we, "R3", "access direction", 32'(tgt_we), 32'(x.we));
                        check(tgt_be == x.be, "R4", "byte enables", 32'(tgt_be), 32'(x.be));
                        if (x.we)
                            check(tgt_wdata == x.wd, "R5", "write lanes", tgt_wdata, x.wd);
                    end
                end
            end
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) begin
                    check(1'b0, "R7", "unexpected response data", rsp_rdata, 32'h0);
                end else begin
                    rsp_t r;
                    r = exp_rsp.pop_front();
                    check(int'(rsp_thread) == r.thr, "R8", "response thread", 32'(rsp_thread), 32'(r.thr));
                    check(rsp_err == r.err, "R11", "error flag", 32'(rsp_err), 32'(r.err));
                    check(rsp_last == r.last, "R7", "last flag", 32'(rsp_last), 32'(r.last));
                    check(rsp_rdata == r.data, "R6", "response data", rsp_rdata, r.data);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog run hung actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(req_ready == 4'hF, "R1", "ready after reset", 32'(req_ready), 32'hF);
        check(tgt_valid == '0, "R1", "no access after reset", 32'(tgt_valid), 32'h0);
        check(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 32'h0);

        // R2: three-edge latency, word read
        expect_burst(0, 1'b0, 32'h0000_4008, 0, 2'd2, '0);
        send(0, 1'b0, 32'h0000_4008, 0, 2'd2, '0);
        check(req_ready[0] == 1'b0, "R1", "slot full after take", 32'(req_ready[0]), 32'h0);
        @(negedge clk);
        check(tgt_valid == '0, "R2", "strobe after edge 1", 32'(tgt_valid), 32'h0);
        check(req_ready[0] == 1'b1, "R1", "slot freed on grant", 32'(req_ready[0]), 32'h1);
        @(negedge clk);
        check(tgt_valid == '0, "R2", "strobe after edge 2", 32'(tgt_valid), 32'h0);
        @(negedge clk);
        check(tgt_valid == 4'b0001, "R2", "strobe after edge 3", 32'(tgt_valid), 32'h1);
        drain();

        // R3 R4 R5: byte write burst crossing a word boundary
        expect_burst(1, 1'b1, 32'h0000_5001, 3, 2'd0, {32'h44, 32'h33, 32'h22, 32'h11});
        send(1, 1'b1, 32'h0000_5001, 3, 2'd0, {32'h44, 32'h33, 32'h22, 32'h11});
        drain();

        // R6: halfword read burst
        expect_burst(2, 1'b0, 32'h0000_6002, 2, 2'd1, '0);
        send(2, 1'b0, 32'h0000_6002, 2, 2'd1, '0);
        drain();

        // R3 R5: word write burst, size code 3
        expect_burst(3, 1'b1, 32'h0000_7000, 3, 2'd3,
                     {32'hDEAD_0004, 32'hBEEF_0003, 32'hCAFE_0002, 32'hF00D_0001});
        send(3, 1'b1, 32'h0000_7000, 3, 2'd3,
             {32'hDEAD_0004, 32'hBEEF_0003, 32'hCAFE_0002, 32'hF00D_0001});
        drain();

        // R6: byte read burst
        expect_burst(0, 1'b0, 32'h0000_4011, 2, 2'd0, '0);
        send(0, 1'b0, 32'h0000_4011, 2, 2'd0, '0);
        drain();

        // R11: decode miss, timed
        expect_fault(1);
        send(1, 1'b0, 32'h0000_1000, 2, 2'd2, '0);
        @(negedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11", "no early error", 32'(rsp_valid), 32'h0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R11", "error after edge 3", 32'(rsp_valid), 32'h1);
        drain();

        // R8 R9 R1: fairness while a long burst runs
        expect_burst(0, 1'b0, 32'h0000_4000, 3, 2'd2, '0);
        expect_burst(1, 1'b0, 32'h0000_5006, 1, 2'd1, '0);
        expect_burst(2, 1'b1, 32'h0000_6003, 1, 2'd0, {64'h0, 32'h0000_00B2, 32'h0000_00B1});
        expect_fault(3);
        expect_burst(0, 1'b1, 32'h0000_7010, 0, 2'd2, {96'h0, 32'h1234_5678});
        send(0, 1'b0, 32'h0000_4000, 3, 2'd2, '0);
        send(0, 1'b1, 32'h0000_7010, 0, 2'd2, {96'h0, 32'h1234_5678});
        check(req_ready[0] == 1'b0, "R1", "thread 0 stalled", 32'(req_ready[0]), 32'h0);
        check(req_ready[2] == 1'b1, "R1", "thread 2 still open", 32'(req_ready[2]), 32'h1);
        send(2, 1'b1, 32'h0000_6003, 1, 2'd0, {64'h0, 32'h0000_00B2, 32'h0000_00B1});
        send(1, 1'b0, 32'h0000_5006, 1, 2'd1, '0);
        send(3, 1'b0, 32'h0000_F000, 0, 2'd2, '0);
        drain();

        check(exp_acc.size() == 0, "R9", "accesses left", 32'(exp_acc.size()), 32'h0);
        check(exp_rsp.size() == 0, "R7", "responses left", 32'(exp_rsp.size()), 32'h0);
        finish_run();
    end

endmodule